// File: doc/BRIEF.md
# Mode-Selectable I2S Receive Front End

This block is the serial front end of an I2S audio receiver. A five-bit control word chooses where its bit clock and its word-select reference come from, whether it runs as a clock master or a slave, and whether it enables a master-clock pin driver. The control word is one `slave_sel` bit plus a four-bit `rx_mode` code. The bit clock can come from four places: an internal fractional rate divider, a reference clock borrowed from the transmitter, the transmitter's bit clock, or an external clock pin. The word-select reference can be the receiver's own generator, the transmitter's word select, or an external pin.

Every clock is modelled as a one-cycle enable pulse inside a single system clock domain. On each selected bit-clock pulse the block samples serial data and word select. It assembles left and right words, MSB first, with the usual one-bit I2S delay, and hands out each complete stereo pair with a one-cycle strobe. A control code outside the defined set parks the receiver in idle, turns off every driver and raises an error flag.

Top module: `i2srx_mode_front`

## Requirements
- R1: With `slave_sel`=0 and `rx_mode`=4'b0000, bit clocks come from the fractional divider and the receiver's own word select is used and driven (`ws_oe`=1). `mclk_oe`=0, and `ws_out` changes only in the cycle after a bit-clock pulse.
- R2: With `slave_sel`=0 and `rx_mode`=4'b1000, the block behaves as in R1 and also sets `mclk_oe`=1. In every other control code `mclk_oe`=0.
- R3: With `slave_sel`=0 and `rx_mode`=4'b0010, bit clocks come from `txref_pulse`, the receiver's own word select is used and driven, and `mclk_oe`=0.
- R4: With `slave_sel`=0 and `rx_mode`=4'b0100, bit clocks come from `txbck_pulse` and word select comes from `tx_ws`, which is driven out on `ws_out` with `ws_oe`=1. `mclk_oe`=0.
- R5: With `slave_sel`=1 and `rx_mode`=4'b0000, bit clocks come from `ext_bck_pulse` and word select from `ext_ws`. In every slave code, `ws_oe`=0 and `ws_out`=0.
- R6: With `slave_sel`=1 and `rx_mode`=4'b0010, bit clocks come from `txref_pulse` and word select from `ext_ws`.
- R7: With `slave_sel`=1 and `rx_mode`=4'b0100, bit clocks come from `txbck_pulse` and word select from `tx_ws`.
- R8: The divider adds `div_num` to a phase accumulator each cycle and emits one bit-clock pulse per wrap past `div_den` (`div_num` ≤ `div_den`). The own word select toggles every N bit clocks, so in steady state its edges are N·`div_den`/`div_num` cycles apart whenever that value is an integer.
- R9: Word width N is 8 for `word_len`=2'b00, 16 for 2'b01, and 32 for 2'b1x. Data is sampled on each selected pulse, MSB first. The first bit of a word is the pulse after the pulse at which word select was first seen at its new level. Word select 0 is left and 1 is right. Words are right-justified with zero upper bits.
- R10: `word_valid` is high for exactly one cycle, after a right word completes that followed a completed left word. A right word with no left word before it produces no strobe.
- R11: Any control code not listed in R1–R7 sets `mode_err`=1, holds `ws_oe`, `mclk_oe` and `word_valid` at 0, and keeps the receiver idle.
- R12: Pulses on the bit-clock inputs that are not selected, and changes on the word-select input that is not selected, have no effect on the received words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_sel | input | 1 | 0 = master operation, 1 = slave operation |
| rx_mode | input | 4 | Clock and word-select routing code |
| div_num | input | DIV_W | Divider increment (numerator) |
| div_den | input | DIV_W | Divider modulus (denominator) |
| word_len | input | 2 | Word width select: 00=8, 01=16, 1x=32 |
| txref_pulse | input | 1 | Transmitter reference clock enable pulse |
| txbck_pulse | input | 1 | Transmitter bit clock enable pulse |
| tx_ws | input | 1 | Transmitter word select |
| ext_bck_pulse | input | 1 | External receive bit clock pin, as a rising-edge pulse |
| ext_ws | input | 1 | External receive word-select pin |
| sd_in | input | 1 | Serial data |
| ws_out | output | 1 | Word select driven in master operation |
| ws_oe | output | 1 | Word-select pin driver enable |
| mclk_oe | output | 1 | Master-clock pin driver enable |
| left_word | output | WORD_W | Last completed left word |
| right_word | output | WORD_W | Last completed right word |
| word_valid | output | 1 | One-cycle strobe for a complete stereo pair |
| mode_err | output | 1 | Reserved control code in use |

## Verification
The bench runs each of the seven legal routings. While it does so, it fires the unused clock inputs and toggles the unused word-select input on every spare cycle. A design that decoded a routing wrongly would pick up this noise and deliver corrupted words. The bench derives its data timing from the word-select level it sees at each pulse, so a design that started a word one pulse early or late, or swapped channels, would show shifted or exchanged words. It expects exactly two strobes from a stream that opens with a lone right word, which catches a strobe on an unpaired word or a strobe held for two cycles. A sweep of all 32 control codes catches a master-clock enable outside its single mode or a word-select driver left on in slave or reserved codes. Edge spacing of the word select at two divider ratios catches an accumulator that drops or adds pulses.

// File: rtl/i2srx_pkg.sv
package i2srx_pkg;

   typedef enum logic [1:0] {
      BCK_DIV   = 2'd0,
      BCK_TXREF = 2'd1,
      BCK_TXBCK = 2'd2,
      BCK_EXT   = 2'd3
   } bck_src_e;

   typedef enum logic [1:0] {
      WS_OWN = 2'd0,
      WS_TX  = 2'd1,
      WS_EXT = 2'd2
   } ws_src_e;

   typedef struct packed {
      logic     legal;
      logic     master;
      bck_src_e bck;
      ws_src_e  ws;
      logic     mclk_en;
   } rx_route_t;

   function automatic rx_route_t decode_route(input logic slave, input logic [3:0] code);
      rx_route_t r;
      r = '{legal: 1'b0, master: 1'b0, bck: BCK_DIV, ws: WS_OWN, mclk_en: 1'b0};
      unique case ({slave, code})
         5'b0_0000: r = '{legal: 1'b1, master: 1'b1, bck: BCK_DIV,   ws: WS_OWN, mclk_en: 1'b0};
         5'b0_0010: r = '{legal: 1'b1, master: 1'b1, bck: BCK_TXREF, ws: WS_OWN, mclk_en: 1'b0};
         5'b0_0100: r = '{legal: 1'b1, master: 1'b1, bck: BCK_TXBCK, ws: WS_TX,  mclk_en: 1'b0};
         5'b0_1000: r = '{legal: 1'b1, master: 1'b1, bck: BCK_DIV,   ws: WS_OWN, mclk_en: 1'b1};
         5'b1_0000: r = '{legal: 1'b1, master: 1'b0, bck: BCK_EXT,   ws: WS_EXT, mclk_en: 1'b0};
         5'b1_0010: r = '{legal: 1'b1, master: 1'b0, bck: BCK_TXREF, ws: WS_EXT, mclk_en: 1'b0};
         5'b1_0100: r = '{legal: 1'b1, master: 1'b0, bck: BCK_TXBCK, ws: WS_TX,  mclk_en: 1'b0};
         default:   r = '{legal: 1'b0, master: 1'b0, bck: BCK_DIV,   ws: WS_OWN, mclk_en: 1'b0};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/i2srx_frac_div.sv
module i2srx_frac_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] num,
   input  logic [DIV_W-1:0] den,
   output logic             tick
);
   localparam int SUM_W = DIV_W + 1;

   logic [DIV_W-1:0] phase_q;
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] wrapped;
   logic             wrap;

   assign sum     = {1'b0, phase_q} + {1'b0, num};
   assign wrapped = sum - {1'b0, den};
   assign wrap    = (den != '0) && (sum >= {1'b0, den});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         tick    <= 1'b0;
      end else if (!run) begin
         phase_q <= '0;
         tick    <= 1'b0;
      end else if (wrap) begin
         phase_q <= wrapped[DIV_W-1:0];
         tick    <= 1'b1;
      end else begin
         phase_q <= (den == '0) ? phase_q : sum[DIV_W-1:0];
         tick    <= 1'b0;
      end
   end
endmodule

// File: rtl/i2srx_ws_gen.sv
module i2srx_ws_gen #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             bit_en,
   input  logic [CNT_W-1:0] word_bits,
   output logic             ws
);
   logic [CNT_W-1:0] cnt_q;
   logic             last_bit;

   assign last_bit = (cnt_q == word_bits - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ws    <= 1'b0;
      end else if (clear) begin
         cnt_q <= '0;
         ws    <= 1'b0;
      end else if (bit_en) begin
         if (last_bit) begin
            cnt_q <= '0;
            ws    <= ~ws;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/i2srx_deser.sv
module i2srx_deser #(
   parameter int WORD_W = 32,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              bit_en,
   input  logic              ws_in,
   input  logic              sd_in,
   input  logic [CNT_W-1:0]  word_bits,
   output logic [WORD_W-1:0] left_word,
   output logic [WORD_W-1:0] right_word,
   output logic              word_valid
);
   logic [WORD_W-2:0] shift_q;
   logic [WORD_W-1:0] shift_next;
   logic [CNT_W-1:0]  cnt_q;
   logic              ws_h1_q;
   logic              ws_h2_q;
   logic              chan_q;
   logic              busy_q;
   logic              have_left_q;
   logic              word_start;
   logic              word_done;

   assign shift_next = {shift_q, sd_in};
   assign word_start = (ws_h1_q != ws_h2_q);
   assign word_done  = busy_q && !word_start && (cnt_q == word_bits - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q     <= '0;
         cnt_q       <= '0;
         ws_h1_q     <= 1'b0;
         ws_h2_q     <= 1'b0;
         chan_q      <= 1'b0;
         busy_q      <= 1'b0;
         have_left_q <= 1'b0;
         left_word   <= '0;
         right_word  <= '0;
         word_valid  <= 1'b0;
      end else if (clear) begin
         shift_q     <= '0;
         cnt_q       <= '0;
         ws_h1_q     <= 1'b0;
         ws_h2_q     <= 1'b0;
         chan_q      <= 1'b0;
         busy_q      <= 1'b0;
         have_left_q <= 1'b0;
         word_valid  <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         if (bit_en) begin
            ws_h1_q <= ws_in;
            ws_h2_q <= ws_h1_q;
            if (word_start) begin
               shift_q <= {{(WORD_W-2){1'b0}}, sd_in};
               cnt_q   <= CNT_W'(1);
               chan_q  <= ws_h1_q;
               busy_q  <= 1'b1;
            end else if (busy_q) begin
               shift_q <= shift_next[WORD_W-2:0];
               cnt_q   <= cnt_q + CNT_W'(1);
               if (word_done) begin
                  busy_q <= 1'b0;
                  if (!chan_q) begin
                     left_word   <= shift_next;
                     have_left_q <= 1'b1;
                  end else begin
                     right_word <= shift_next;
                     if (have_left_q) begin
                        word_valid  <= 1'b1;
                        have_left_q <= 1'b0;
                     end
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/i2srx_mode_front.sv
module i2srx_mode_front
   import i2srx_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slave_sel,
   input  logic [3:0]        rx_mode,
   input  logic [DIV_W-1:0]  div_num,
   input  logic [DIV_W-1:0]  div_den,
   input  logic [1:0]        word_len,
   input  logic              txref_pulse,
   input  logic              txbck_pulse,
   input  logic              tx_ws,
   input  logic              ext_bck_pulse,
   input  logic              ext_ws,
   input  logic              sd_in,
   output logic              ws_out,
   output logic              ws_oe,
   output logic              mclk_oe,
   output logic [WORD_W-1:0] left_word,
   output logic [WORD_W-1:0] right_word,
   output logic              word_valid,
   output logic              mode_err
);
   localparam int CNT_W  = $clog2(WORD_W + 1);
   localparam int N_SRC  = 4;

   if (DIV_W < 2) begin : g_bad_div
      $error("DIV_W must be at least 2");
   end
   if (WORD_W < 17 || WORD_W > 64) begin : g_bad_word
      $error("WORD_W must lie in 17..64");
   end

   rx_route_t        route;
   logic [N_SRC-1:0] src_vec;
   logic [N_SRC-1:0] src_hit;
   logic             div_tick;
   logic             div_run;
   logic             bit_en;
   logic             own_ws;
   logic             own_ws_lvl;
   logic             ws_sel;
   logic [CNT_W-1:0] word_bits;

   assign route   = decode_route(slave_sel, rx_mode);
   assign div_run = route.legal && (route.bck == BCK_DIV);
   assign own_ws  = route.legal && (route.ws == WS_OWN);

   always_comb begin
      unique case (word_len)
         2'b00:   word_bits = CNT_W'(8);
         2'b01:   word_bits = CNT_W'(16);
         default: word_bits = CNT_W'(WORD_W);
      endcase
   end

   i2srx_frac_div #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (div_run),
      .num   (div_num),
      .den   (div_den),
      .tick  (div_tick)
   );

   assign src_vec[BCK_DIV]   = div_tick;
   assign src_vec[BCK_TXREF] = txref_pulse;
   assign src_vec[BCK_TXBCK] = txbck_pulse;
   assign src_vec[BCK_EXT]   = ext_bck_pulse;

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      assign src_hit[g] = src_vec[g] && (route.bck == bck_src_e'(g));
   end

   assign bit_en = route.legal && (|src_hit);

   i2srx_ws_gen #(.CNT_W(CNT_W)) u_wsgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (!own_ws),
      .bit_en    (bit_en),
      .word_bits (word_bits),
      .ws        (own_ws_lvl)
   );

   always_comb begin
      unique case (route.ws)
         WS_OWN:  ws_sel = own_ws_lvl;
         WS_TX:   ws_sel = tx_ws;
         default: ws_sel = ext_ws;
      endcase
   end

   i2srx_deser #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_deser (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (!route.legal),
      .bit_en     (bit_en),
      .ws_in      (ws_sel),
      .sd_in      (sd_in),
      .word_bits  (word_bits),
      .left_word  (left_word),
      .right_word (right_word),
      .word_valid (word_valid)
   );

   assign ws_oe    = route.legal && route.master;
   assign ws_out   = ws_oe && ws_sel;
   assign mclk_oe  = route.legal && route.mclk_en;
   assign mode_err = !route.legal;

endmodule

// File: rtl/i2srx_chk.sv
module i2srx_chk #(
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              slave_sel,
   input logic [1:0]        word_len,
   input logic              ws_out,
   input logic              ws_oe,
   input logic              mclk_oe,
   input logic              mode_err,
   input logic              word_valid,
   input logic [WORD_W-1:0] right_word,
   input logic              bit_en,
   input logic              own_ws
);
   // R11: reserved code keeps drivers off and suppresses strobes
   p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> (!ws_oe && !mclk_oe));
   p_err_nostrobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |=> !word_valid);

   // R5: slave operation never drives word select
   p_slave_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      slave_sel |-> (!ws_oe && !ws_out));

   // R2: master clock only accompanies master operation
   p_mclk_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mclk_oe |-> (ws_oe && !slave_sel));

   // R10: strobe lasts one cycle
   p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   // R1: own word select moves only after a bit-clock pulse
   p_ws_on_bclk_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (own_ws && $past(own_ws) && !$stable(ws_out)) |-> $past(bit_en));

   // R9: 8-bit words are right-justified
   p_narrow_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && $past(word_len) == 2'b00) |-> (right_word[WORD_W-1:8] == '0));
endmodule

bind i2srx_mode_front i2srx_chk #(.WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .slave_sel  (slave_sel),
   .word_len   (word_len),
   .ws_out     (ws_out),
   .ws_oe      (ws_oe),
   .mclk_oe    (mclk_oe),
   .mode_err   (mode_err),
   .word_valid (word_valid),
   .right_word (right_word),
   .bit_en     (bit_en),
   .own_ws     (own_ws)
);

// File: tb/i2srx_mode_front_tb_top.sv
`timescale 1ns/1ps
module i2srx_mode_front_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slave_sel = 1'b1;
   logic [3:0]  rx_mode = 4'hF;
   logic [7:0]  div_num = 8'd0;
   logic [7:0]  div_den = 8'd0;
   logic [1:0]  word_len = 2'b00;
   logic        txref_pulse = 1'b0;
   logic        txbck_pulse = 1'b0;
   logic        tx_ws = 1'b0;
   logic        ext_bck_pulse = 1'b0;
   logic        ext_ws = 1'b0;
   logic        sd_in = 1'b0;
   logic        ws_out, ws_oe, mclk_oe, word_valid, mode_err;
   logic [31:0] left_word, right_word;

   int     checks = 0;
   int     failures = 0;
   longint cyc = 0;

   always #2 clk = ~clk;

   i2srx_mode_front #(.DIV_W(8), .WORD_W(32)) dut_i (
      .clk(clk), .rst_n(rst_n), .slave_sel(slave_sel), .rx_mode(rx_mode),
      .div_num(div_num), .div_den(div_den), .word_len(word_len),
      .txref_pulse(txref_pulse), .txbck_pulse(txbck_pulse), .tx_ws(tx_ws),
      .ext_bck_pulse(ext_bck_pulse), .ext_ws(ext_ws), .sd_in(sd_in),
      .ws_out(ws_out), .ws_oe(ws_oe), .mclk_oe(mclk_oe),
      .left_word(left_word), .right_word(right_word),
      .word_valid(word_valid), .mode_err(mode_err)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      slave_sel = 1'b1; rx_mode = 4'hF;
      txref_pulse = 0; txbck_pulse = 0; ext_bck_pulse = 0;
      tx_ws = 0; ext_ws = 0; sd_in = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic bit code_legal(input bit s, input logic [3:0] m);
      if (!s) return (m == 4'b0000 || m == 4'b0010 || m == 4'b0100 || m == 4'b1000);
      return (m == 4'b0000 || m == 4'b0010 || m == 4'b0100);
   endfunction

   task automatic t_reset_state();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(word_valid == 1'b0, "R10", "strobe in reset", word_valid, 0);
      chk(left_word == 32'd0 && right_word == 32'd0, "R9", "words in reset", left_word, 0);
      chk(mode_err == 1'b1, "R11", "err with reserved code in reset", mode_err, 1);
      chk(ws_oe == 1'b0 && ws_out == 1'b0, "R11", "ws driver in reset", ws_oe, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_decode_sweep();
      do_reset();
      for (int s = 0; s < 2; s++) begin
         for (int m = 0; m < 16; m++) begin
            bit lg;
            @(negedge clk);
            slave_sel = s[0]; rx_mode = m[3:0];
            #1;
            lg = code_legal(s[0], m[3:0]);
            chk(mode_err == !lg, "R11", $sformatf("err flag s=%0d m=%0h", s, m), mode_err, !lg);
            chk(ws_oe == (lg && s == 0), "R5", $sformatf("ws_oe s=%0d m=%0h", s, m), ws_oe, lg && s == 0);
            chk(mclk_oe == (lg && s == 0 && m == 8), "R2", $sformatf("mclk_oe s=%0d m=%0h", s, m),
                mclk_oe, lg && s == 0 && m == 8);
         end
      end
   endtask

   // bsrc: 0 divider, 1 txref, 2 txbck, 3 external; wsrc: 0 own, 1 tx, 2 external
   task automatic run_stream(input string req, input bit s, input logic [3:0] m,
                             input int bsrc, input int wsrc, input int gap,
                             input logic [1:0] len, input logic [31:0] lw, input logic [31:0] rw);
      int n, npulses, pulses, idx, nvalid, tail, cnum;
      bit h1, h2, prev_v, w, is_p;
      logic [31:0] mask, word;
      n = (len == 2'b00) ? 8 : ((len == 2'b01) ? 16 : 32);
      mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
      npulses = 6 * n + 1;
      do_reset();
      slave_sel = s; rx_mode = m; word_len = len;
      div_num = 8'd5; div_den = 8'd5;
      pulses = 0; idx = 0; nvalid = 0; tail = 0; cnum = 0;
      h1 = 0; h2 = 0; prev_v = 0;
      while (pulses < npulses || tail < 3) begin
         @(negedge clk);
         if (word_valid) begin
            nvalid++;
            chk(left_word == (lw & mask), req, "left word", left_word, lw & mask);
            chk(right_word == (rw & mask), req, "right word", right_word, rw & mask);
            chk(!prev_v, "R10", "strobe wider than one cycle", 1, 0);
         end
         prev_v = word_valid;
         // R12: unselected sources get random activity
         txref_pulse   = (bsrc != 1) ? 1'($urandom % 2) : 1'b0;
         txbck_pulse   = (bsrc != 2) ? 1'($urandom % 2) : 1'b0;
         ext_bck_pulse = (bsrc != 3) ? 1'($urandom % 2) : 1'b0;
         if (wsrc != 1) tx_ws  = 1'($urandom % 2);
         if (wsrc != 2) ext_ws = 1'($urandom % 2);
         if (pulses >= npulses) begin
            tail++;
            sd_in = 1'($urandom % 2);
         end else begin
            is_p = ((cnum % gap) == 0);
            cnum++;
            if (is_p) begin
               w = (wsrc == 0) ? ws_out : 1'((pulses / n) % 2);
               if (wsrc == 1) tx_ws = w;
               if (wsrc == 2) ext_ws = w;
               if (h1 != h2) idx = 0; else idx++;
               word = h1 ? rw : lw;
               sd_in = (idx < n) ? word[n-1-idx] : 1'b0;
               h2 = h1; h1 = w;
               case (bsrc)
                  1: txref_pulse = 1'b1;
                  2: txbck_pulse = 1'b1;
                  3: ext_bck_pulse = 1'b1;
                  default: ;
               endcase
               pulses++;
            end else begin
               sd_in = 1'($urandom % 2);
            end
         end
      end
      chk(nvalid == 2, "R10", {req, " strobe count"}, nvalid, 2);
      chk(ws_oe == !s, req, "ws driver enable", ws_oe, !s);
      chk(mclk_oe == (!s && m == 4'b1000), "R2", {req, " mclk enable"}, mclk_oe, !s && m == 4'b1000);
   endtask

   task automatic t_div_rate(input logic [7:0] x, input logic [7:0] y,
                             input logic [1:0] len, input longint exp_gap);
      longint t[3];
      int e;
      bit pw;
      do_reset();
      slave_sel = 0; rx_mode = 4'b0000; word_len = len;
      div_num = x; div_den = y;
      e = 0; pw = 0;
      for (int k = 0; k < 3000 && e < 3; k++) begin
         @(negedge clk);
         if (ws_out != pw) begin
            t[e] = cyc;
            e++;
            pw = ws_out;
         end
      end
      chk(e == 3, "R8", "ws edges seen", e, 3);
      if (e == 3) chk(t[2] - t[1] == exp_gap, "R8", "ws edge spacing", t[2] - t[1], exp_gap);
   endtask

   task automatic t_reserved(input bit s, input logic [3:0] m);
      int nv, noe;
      do_reset();
      slave_sel = s; rx_mode = m; word_len = 2'b00;
      div_num = 8'd1; div_den = 8'd1;
      nv = 0; noe = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (word_valid) nv++;
         if (ws_oe || mclk_oe || ws_out) noe++;
         txref_pulse = 1'($urandom % 2); txbck_pulse = 1'($urandom % 2);
         ext_bck_pulse = 1'($urandom % 2); tx_ws = 1'($urandom % 2);
         ext_ws = 1'($urandom % 2); sd_in = 1'($urandom % 2);
      end
      chk(nv == 0, "R11", $sformatf("strobes in reserved s=%0d m=%0h", s, m), nv, 0);
      chk(noe == 0, "R11", "drivers active in reserved", noe, 0);
      chk(mode_err == 1'b1, "R11", "error flag", mode_err, 1);
   endtask

   initial begin
      t_reset_state();
      t_decode_sweep();
      run_stream("R1",  0, 4'b0000, 0, 0, 1, 2'b00, 32'h0000_00A5, 32'h0000_003C);
      run_stream("R2",  0, 4'b1000, 0, 0, 1, 2'b01, 32'h0000_9AC3, 32'h0000_5E17);
      run_stream("R3",  0, 4'b0010, 1, 0, 2, 2'b10, 32'hC0DE_1234, 32'h8BAD_F00D);
      run_stream("R4",  0, 4'b0100, 2, 1, 3, 2'b00, 32'h0000_0081, 32'h0000_007E);
      run_stream("R5",  1, 4'b0000, 3, 2, 2, 2'b01, 32'h0000_F00F, 32'h0000_1248);
      run_stream("R6",  1, 4'b0010, 1, 2, 1, 2'b11, 32'h7654_3210, 32'hFEDC_BA98);
      run_stream("R7",  1, 4'b0100, 2, 1, 2, 2'b00, 32'h0000_0013, 32'h0000_00EC);
      run_stream("R12", 1, 4'b0000, 3, 2, 3, 2'b00, 32'h0000_0055, 32'h0000_00AA);
      run_stream("R9",  0, 4'b0010, 1, 0, 1, 2'b01, 32'hFFFF_8001, 32'hFFFF_7FFE);
      t_div_rate(8'd2, 8'd5, 2'b00, 20);
      t_div_rate(8'd1, 8'd4, 2'b01, 64);
      t_reserved(1'b1, 4'b1000);
      t_reserved(1'b0, 4'b0110);
      t_reserved(1'b0, 4'b0001);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule